// File: doc/BRIEF.md
# Serial Command Register Interface

This block is a serial slave that takes configuration commands of 8 or 16 bits, MSB first, over a chip-select / clock / data link. The link is oversampled by the block's own system clock. Each frame is decoded by the leading bits of its first byte. A frame whose length matches its command updates one configuration register. Every register comes back to its default on reset or on a dedicated software-reset word. The register fields leave the block as plain outputs that feed the synthesizer, amplifier, battery monitor, wake timer and push-button logic elsewhere on the chip.

A status-read command lets the host fetch a 16-bit status word. The word is captured once the command byte is complete. It is then shifted out MSB first on a separate output pin, one bit on each falling serial clock edge. That pin rests high at all other times.

Top module: `spi_cmd_if`

## Requirements
- R1: Data is sampled on a rising serial clock edge only while chip select is low. Chip select high clears the bit counter, so bits from an aborted frame do not count toward the next frame.
- R2: A register changes only in the cycle that follows the rising edge of chip select that closes a frame of exactly the command's length. Frames of 12 or 24 bits, and 8-bit frames whose code is not the 8-bit power code, change nothing.
- R3: 16-bit commands decode by prefix. Each stores its parameter bits as follows:
  - 100 stores bits 12:0 as the configuration register: band in bits 12:11, clock divider in 10:8, crystal load in 7:4, deviation polarity in 3, deviation step in 2:0.
  - 1010 stores bits 11:0 as the frequency word.
  - 11000000 stores the low byte as power-enable bits.
  - 11001000 stores the low byte as the data-rate word.
  - 11000010 stores the low byte as battery-detector flags in bits 7:5 and the threshold T in bits 4:0.
  - 11000100 stores the low byte as sleep tail length.
  - 11001010 stores the low byte as button settings.
  - 111 stores bits 12:8 as timer exponent and bits 7:0 as timer mantissa.
  - 11010010 stores the low byte as PLL settings.
  - Any other prefix stores nothing.
- R4: An 8-bit frame whose upper nibble is 1011 sets the amplifier on-off-keying flag from bit 3 and the attenuation step from bits 2:0. A 16-bit frame with that prefix is ignored.
- R5: After reset the outputs equal the defaults:
  - configuration 0x0080
  - power-enable 0x00
  - frequency 0x7D0
  - rate 0x00
  - amplifier 0x0
  - battery 0x00
  - sleep tail 0x10
  - buttons 0x00
  - timer 0
  - PLL 0x00
  - status pin high
- R6: A frequency word is accepted only when it lies in 96..3903 inclusive. Otherwise the previous frequency word is kept.
- R7: The 16-bit word 0xFE00 restores every default, as reset does, and does not act as a timer write.
- R8: A frame whose first byte is 0xCC captures the status input after its 8th bit. It drives the status bits MSB first on the status pin, one bit per falling serial clock edge starting with the 8th falling edge. The pin is high outside a read, and the read changes no register.
- R9: The battery threshold output in millivolts equals 2250 + 100 × T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| status_in | input | 16 | Status word offered for a status read |
| stat_o | output | 1 | Serial status output, high when idle |
| band | output | 2 | Band select |
| clk_div | output | 3 | Host clock divider |
| xtal_load | output | 4 | Crystal load capacitance step |
| dev_pol | output | 1 | Deviation polarity |
| dev_step | output | 3 | Deviation step |
| pm_en | output | 8 | Power-enable bits |
| freq_word | output | 12 | Carrier frequency word |
| rate_word | output | 8 | Data-rate word |
| pa_ook | output | 1 | Amplifier on-off keying enable |
| pa_atten | output | 3 | Amplifier attenuation step |
| lbd_flags | output | 3 | Battery-detector control flags |
| lbd_thresh | output | 5 | Battery threshold code T |
| lbd_mv | output | 13 | Battery threshold in millivolts |
| sleep_tail | output | 8 | Clock tail length after sleep |
| btn_cfg | output | 8 | Push-button settings |
| wut_exp | output | 5 | Wake timer exponent |
| wut_mant | output | 8 | Wake timer mantissa |
| pll_cfg | output | 8 | PLL settings |

## Verification
The assertions check on every cycle the following:
- no register moves except on a commit;
- a commit only ever coincides with a chip-select rise;
- the frequency word never leaves its legal window;
- the bit counter clears while deselected and steps once per sampled edge;
- the status pin is high outside a read and holds between falling edges.

Only the bench's scenarios can show that each prefix lands its bits in the right field. The same holds for wrong-length and unknown frames being dropped, and for the boundary frequency values 95, 96, 3903 and 3904. They also show that the status bits arrive in order and that the software-reset word wins over a timer write.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int CMD_W     = 16;
  localparam int CNT_W     = 5;
  localparam int FREQ_W    = 12;
  localparam int FREQ_MIN  = 96;
  localparam int FREQ_MAX  = 3903;
  localparam int MV_W      = 13;
  localparam logic [CMD_W-1:0] SWRST_WORD = 16'hFE00;
  localparam logic [7:0]       RD_CODE    = 8'hCC;

  typedef enum logic [3:0] {
    K_NONE, K_CFG, K_FREQ, K_PM, K_RATE, K_PWR, K_LBD,
    K_SLP, K_BTN, K_WUT, K_PLL, K_SWRST
  } cmd_kind_e;

  typedef struct packed {
    logic [12:0]       cfg;
    logic [7:0]        pm;
    logic [FREQ_W-1:0] freq;
    logic [7:0]        rate;
    logic [3:0]        pwr;
    logic [7:0]        lbd;
    logic [7:0]        slp;
    logic [7:0]        btn;
    logic [12:0]       wut;
    logic [7:0]        pll;
  } regs_t;

  localparam regs_t REGS_DEFAULT = '{
    cfg: 13'h0080, pm: 8'h00, freq: 12'h7D0, rate: 8'h00, pwr: 4'h0,
    lbd: 8'h00, slp: 8'h10, btn: 8'h00, wut: 13'h0000, pll: 8'h00
  };

  // Classify a closed frame from its collected bits and length
  function automatic cmd_kind_e decode_cmd(input logic [CMD_W-1:0] w,
                                           input logic [CNT_W-1:0] n);
    cmd_kind_e k;
    k = K_NONE;
    if (n == CNT_W'(16)) begin
      if (w == SWRST_WORD) k = K_SWRST;
      else begin
        casez (w[15:8])
          8'b100?????: k = K_CFG;
          8'b1010????: k = K_FREQ;
          8'b11000000: k = K_PM;
          8'b11001000: k = K_RATE;
          8'b11000010: k = K_LBD;
          8'b11000100: k = K_SLP;
          8'b11001010: k = K_BTN;
          8'b111?????: k = K_WUT;
          8'b11010010: k = K_PLL;
          default:     k = K_NONE;
        endcase
      end
    end else if (n == CNT_W'(8) && w[7:4] == 4'b1011) begin
      k = K_PWR;
    end
    return k;
  endfunction

  function automatic logic freq_ok(input logic [FREQ_W-1:0] f);
    return (f >= FREQ_W'(FREQ_MIN)) && (f <= FREQ_W'(FREQ_MAX));
  endfunction

  function automatic logic [MV_W-1:0] lbd_millivolts(input logic [4:0] t);
    return MV_W'(2250) + MV_W'(t) * MV_W'(100);
  endfunction

endpackage

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sdi,
  output logic             cs_low,
  output logic             cs_rise,
  output logic             sck_rise,
  output logic             sck_fall,
  output logic             byte_pulse,
  output logic [CMD_W-1:0] frame_word,
  output logic [CNT_W-1:0] frame_bits
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES:0]   cs_pipe;
  logic [SYNC_STAGES:0]   sck_pipe;
  logic [SYNC_STAGES-1:0] sdi_pipe;
  logic                   sdi_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe  <= '1;
      sck_pipe <= '0;
      sdi_pipe <= '0;
    end else begin
      cs_pipe  <= {cs_pipe[SYNC_STAGES-1:0], cs_n};
      sck_pipe <= {sck_pipe[SYNC_STAGES-1:0], sck};
      sdi_pipe <= {sdi_pipe[SYNC_STAGES-2:0], sdi};
    end
  end

  assign cs_low   = ~cs_pipe[SYNC_STAGES-1];
  assign cs_rise  = cs_pipe[SYNC_STAGES-1] & ~cs_pipe[SYNC_STAGES];
  assign sck_rise = sck_pipe[SYNC_STAGES-1] & ~sck_pipe[SYNC_STAGES];
  assign sck_fall = ~sck_pipe[SYNC_STAGES-1] & sck_pipe[SYNC_STAGES];
  assign sdi_now  = sdi_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_word <= '0;
      frame_bits <= '0;
      byte_pulse <= 1'b0;
    end else if (!cs_low) begin
      frame_word <= '0;
      frame_bits <= '0;
      byte_pulse <= 1'b0;
    end else begin
      byte_pulse <= sck_rise && (frame_bits == CNT_W'(7));
      if (sck_rise) begin
        frame_word <= {frame_word[CMD_W-2:0], sdi_now};
        if (frame_bits != CNT_MAX) frame_bits <= frame_bits + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_rise,
  input  logic [CMD_W-1:0] frame_word,
  input  logic [CNT_W-1:0] frame_bits,
  output logic             commit,
  output logic             sw_reset,
  output regs_t            regs
);

  cmd_kind_e kind;

  assign kind     = decode_cmd(frame_word, frame_bits);
  assign commit   = cs_rise && (kind != K_NONE);
  assign sw_reset = commit && (kind == K_SWRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= REGS_DEFAULT;
    end else if (commit) begin
      unique case (kind)
        K_SWRST: regs <= REGS_DEFAULT;
        K_CFG:   regs.cfg  <= frame_word[12:0];
        K_FREQ:  if (freq_ok(frame_word[11:0])) regs.freq <= frame_word[11:0];
        K_PM:    regs.pm   <= frame_word[7:0];
        K_RATE:  regs.rate <= frame_word[7:0];
        K_PWR:   regs.pwr  <= frame_word[3:0];
        K_LBD:   regs.lbd  <= frame_word[7:0];
        K_SLP:   regs.slp  <= frame_word[7:0];
        K_BTN:   regs.btn  <= frame_word[7:0];
        K_WUT:   regs.wut  <= frame_word[12:0];
        K_PLL:   regs.pll  <= frame_word[7:0];
        default: regs <= regs;
      endcase
    end
  end

endmodule

// File: rtl/spi_cmd_status.sv
module spi_cmd_status
  import spi_cmd_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_low,
  input  logic              cs_rise,
  input  logic              sck_fall,
  input  logic              byte_pulse,
  input  logic [7:0]        first_byte,
  input  logic [STAT_W-1:0] status_in,
  output logic              rd_active,
  output logic              stat_o
);

  logic [STAT_W-1:0] shift_q;
  logic              rd_start;

  assign rd_start = cs_low && byte_pulse && (first_byte == RD_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      shift_q   <= '0;
      stat_o    <= 1'b1;
    end else if (cs_rise) begin
      rd_active <= 1'b0;
      stat_o    <= 1'b1;
    end else if (rd_start) begin
      rd_active <= 1'b1;
      shift_q   <= status_in;
    end else if (rd_active && sck_fall) begin
      stat_o  <= shift_q[STAT_W-1];
      shift_q <= {shift_q[STAT_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_cmd_if.sv
module spi_cmd_if
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic [STAT_W-1:0] status_in,
  output logic              stat_o,
  output logic [1:0]        band,
  output logic [2:0]        clk_div,
  output logic [3:0]        xtal_load,
  output logic              dev_pol,
  output logic [2:0]        dev_step,
  output logic [7:0]        pm_en,
  output logic [11:0]       freq_word,
  output logic [7:0]        rate_word,
  output logic              pa_ook,
  output logic [2:0]        pa_atten,
  output logic [2:0]        lbd_flags,
  output logic [4:0]        lbd_thresh,
  output logic [12:0]       lbd_mv,
  output logic [7:0]        sleep_tail,
  output logic [7:0]        btn_cfg,
  output logic [4:0]        wut_exp,
  output logic [7:0]        wut_mant,
  output logic [7:0]        pll_cfg
);

  // Named internal events, also observed by the bound checker
  logic             cs_low, cs_rise, sck_rise, sck_fall, byte_pulse;
  logic             commit, sw_reset, rd_active;
  logic [CMD_W-1:0] frame_word;
  logic [CNT_W-1:0] bit_cnt;
  regs_t            regs;

  spi_cmd_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .cs_low(cs_low), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .byte_pulse(byte_pulse),
    .frame_word(frame_word), .frame_bits(bit_cnt)
  );

  spi_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise),
    .frame_word(frame_word), .frame_bits(bit_cnt),
    .commit(commit), .sw_reset(sw_reset), .regs(regs)
  );

  spi_cmd_status #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_rise(cs_rise),
    .sck_fall(sck_fall), .byte_pulse(byte_pulse),
    .first_byte(frame_word[7:0]), .status_in(status_in),
    .rd_active(rd_active), .stat_o(stat_o)
  );

  assign band       = regs.cfg[12:11];
  assign clk_div    = regs.cfg[10:8];
  assign xtal_load  = regs.cfg[7:4];
  assign dev_pol    = regs.cfg[3];
  assign dev_step   = regs.cfg[2:0];
  assign pm_en      = regs.pm;
  assign freq_word  = regs.freq;
  assign rate_word  = regs.rate;
  assign pa_ook     = regs.pwr[3];
  assign pa_atten   = regs.pwr[2:0];
  assign lbd_flags  = regs.lbd[7:5];
  assign lbd_thresh = regs.lbd[4:0];
  assign lbd_mv     = lbd_millivolts(regs.lbd[4:0]);
  assign sleep_tail = regs.slp;
  assign btn_cfg    = regs.btn;
  assign wut_exp    = regs.wut[12:8];
  assign wut_mant   = regs.wut[7:0];
  assign pll_cfg    = regs.pll;

endmodule

// File: rtl/spi_cmd_if_chk.sv
module spi_cmd_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_low,
  input logic        cs_rise,
  input logic        sck_rise,
  input logic        sck_fall,
  input logic        commit,
  input logic        sw_reset,
  input logic        rd_active,
  input logic        stat_o,
  input logic [4:0]  bit_cnt,
  input logic [11:0] freq_word,
  input logic [7:0]  rate_word,
  input logic [7:0]  pm_en
);

  AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> bit_cnt == 5'd0);  // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cs_low && sck_rise && bit_cnt != 5'd31 |=> bit_cnt == $past(bit_cnt) + 5'd1);  // R1

  AST_COMMIT_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> cs_rise);  // R2

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(freq_word) && $stable(rate_word) && $stable(pm_en));  // R2

  AST_FREQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    freq_word >= 12'd96 && freq_word <= 12'd3903);  // R6

  AST_SWRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> freq_word == 12'h7D0 && rate_word == 8'h00 && pm_en == 8'h00);  // R7

  AST_STAT_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |-> stat_o);  // R8

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active && !sck_fall && !cs_rise |=> $stable(stat_o));  // R8

endmodule

bind spi_cmd_if spi_cmd_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_rise(cs_rise),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .commit(commit),
  .sw_reset(sw_reset), .rd_active(rd_active), .stat_o(stat_o),
  .bit_cnt(bit_cnt), .freq_word(freq_word), .rate_word(rate_word),
  .pm_en(pm_en)
);

// File: tb/spi_cmd_if_bench.sv
module spi_cmd_if_bench;

  localparam int HALF = 8;  // system clocks per serial half period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [15:0] status_in = 16'h0000;
  logic        stat_o, dev_pol, pa_ook;
  logic [1:0]  band;
  logic [2:0]  clk_div, dev_step, pa_atten, lbd_flags;
  logic [3:0]  xtal_load;
  logic [7:0]  pm_en, rate_word, sleep_tail, btn_cfg, wut_mant, pll_cfg;
  logic [11:0] freq_word;
  logic [4:0]  lbd_thresh, wut_exp;
  logic [12:0] lbd_mv;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  spi_cmd_if u_spi_cmd_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .status_in(status_in), .stat_o(stat_o), .band(band), .clk_div(clk_div),
    .xtal_load(xtal_load), .dev_pol(dev_pol), .dev_step(dev_step),
    .pm_en(pm_en), .freq_word(freq_word), .rate_word(rate_word),
    .pa_ook(pa_ook), .pa_atten(pa_atten), .lbd_flags(lbd_flags),
    .lbd_thresh(lbd_thresh), .lbd_mv(lbd_mv), .sleep_tail(sleep_tail),
    .btn_cfg(btn_cfg), .wut_exp(wut_exp), .wut_mant(wut_mant),
    .pll_cfg(pll_cfg)
  );

  // {frame length, word (MSB first), field select, requirement, expected}
  localparam int NV = 21;
  localparam logic [55:0] VEC [NV] = '{
    {8'd16, 16'h9A5B, 8'd0,  8'd3, 16'h1A5B},  // R3 configuration fields
    {8'd16, 16'hA123, 8'd1,  8'd3, 16'h0123},  // R3 frequency
    {8'd16, 16'hA05F, 8'd1,  8'd6, 16'h0123},  // R6 95 rejected
    {8'd16, 16'hA060, 8'd1,  8'd6, 16'h0060},  // R6 96 accepted
    {8'd16, 16'hAF3F, 8'd1,  8'd6, 16'h0F3F},  // R6 3903 accepted
    {8'd16, 16'hAF40, 8'd1,  8'd6, 16'h0F3F},  // R6 3904 rejected
    {8'd16, 16'hC0A5, 8'd2,  8'd3, 16'h00A5},  // R3 power enables
    {8'd16, 16'hC83C, 8'd3,  8'd3, 16'h003C},  // R3 data rate
    {8'd8,  16'hBD00, 8'd4,  8'd4, 16'h000D},  // R4 8-bit amplifier
    {8'd16, 16'hB702, 8'd4,  8'd4, 16'h000D},  // R4 16-bit with that prefix
    {8'd16, 16'hC2BF, 8'd5,  8'd3, 16'h00BF},  // R3 battery fields
    {8'd16, 16'hC2BF, 8'd6,  8'd9, 16'd5350},  // R9 T=31
    {8'd16, 16'hC205, 8'd6,  8'd9, 16'd2750},  // R9 T=5
    {8'd16, 16'hC433, 8'd7,  8'd3, 16'h0033},  // R3 sleep tail
    {8'd16, 16'hCA9C, 8'd8,  8'd3, 16'h009C},  // R3 buttons
    {8'd16, 16'hE5A7, 8'd9,  8'd3, 16'h05A7},  // R3 wake timer
    {8'd16, 16'hD26E, 8'd10, 8'd3, 16'h006E},  // R3 PLL
    {8'd12, 16'hA0C8, 8'd1,  8'd2, 16'h0F3F},  // R2 short frame
    {8'd24, 16'hA0C8, 8'd1,  8'd2, 16'h0F3F},  // R2 long frame
    {8'd16, 16'h4ABC, 8'd2,  8'd3, 16'h00A5},  // R3 unknown prefix
    {8'd8,  16'hC000, 8'd2,  8'd2, 16'h00A5}   // R2 8-bit non-amplifier code
  };

  function automatic logic [15:0] field(input int sel);
    case (sel)
      0:  return {3'b0, band, clk_div, xtal_load, dev_pol, dev_step};
      1:  return {4'b0, freq_word};
      2:  return {8'b0, pm_en};
      3:  return {8'b0, rate_word};
      4:  return {12'b0, pa_ook, pa_atten};
      5:  return {8'b0, lbd_flags, lbd_thresh};
      6:  return {3'b0, lbd_mv};
      7:  return {8'b0, sleep_tail};
      8:  return {8'b0, btn_cfg};
      9:  return {3'b0, wut_exp, wut_mant};
      10: return {8'b0, pll_cfg};
      default: return 16'hDEAD;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends len bits MSB first (zeros past bit 16); captures stat_o before rises 9..24
  task automatic xfer(input int len, input logic [15:0] w, output logic [15:0] cap);
    cap = '0;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < len; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(HALF);
      if (i >= 8 && i < 24) cap[23-i] = stat_o;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic check_defaults(input string req);
    check(req, field(0), 16'h0080);
    check(req, field(1), 16'h07D0);
    check(req, field(2), 16'h0000);
    check(req, field(3), 16'h0000);
    check(req, field(4), 16'h0000);
    check(req, field(5), 16'h0000);
    check(req, field(6), 16'd2250);
    check(req, field(7), 16'h0010);
    check(req, field(8), 16'h0000);
    check(req, field(9), 16'h0000);
    check(req, field(10), 16'h0000);
    check(req, {15'b0, stat_o}, 16'h0001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] cap;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check_defaults("R5");

    for (int v = 0; v < NV; v++) begin
      xfer(int'(VEC[v][55:48]), VEC[v][47:32], cap);
      check($sformatf("R%0d vec%0d", VEC[v][23:16], v),
            field(int'(VEC[v][31:24])), VEC[v][15:0]);
    end

    // R1: aborted 5-bit frame must not offset the next frame
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      sdi = 1'b1;
      wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(10);
    check("R1 aborted", field(3), 16'h003C);
    xfer(16, 16'hC877, cap);
    check("R1 after abort", field(3), 16'h0077);

    // R8: status read, MSB first, idle high, registers untouched
    status_in = 16'hB38E;
    xfer(24, 16'hCC00, cap);
    check("R8 bits", cap, 16'hB38E);
    check("R8 idle", {15'b0, stat_o}, 16'h0001);
    check("R8 no write", field(3), 16'h0077);
    status_in = 16'h4C71;
    xfer(24, 16'hCC00, cap);
    check("R8 bits2", cap, 16'h4C71);

    // R7: software reset word beats a timer write
    xfer(16, 16'hA321, cap);
    check("R7 pre", field(1), 16'h0321);
    xfer(16, 16'hFE00, cap);
    check_defaults("R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule